// File: doc/BRIEF.md
# Conditional Skip Evaluator

This block sits beside the execute stage of a small 16-bit processor and decides, for every instruction the decoder hands over, whether that instruction is carried out or passed over. Eight conditional-test operations are supported: two bit tests (any common bit set, no common bit set), equality and inequality, and greater-than and less-than comparisons in both unsigned and two's-complement signed form. A test that holds lets the next instruction run. A test that fails marks the next instruction to be passed over.

The decoder presents one instruction per `in_valid` strobe. With it come a flag saying whether the instruction is a conditional test, the test code, the b and a operand values, and the instruction's encoded length in words (1 to 3). One cycle later the block reports whether that instruction is skipped. For a skipped instruction it also reports how many words the fetch unit must step over, so that inline literal words are never fetched as opcodes. A conditional test that is itself skipped is not evaluated. Skipping then carries on through the instruction after it, and ends once a non-conditional instruction has been passed over. A skipped instruction has no side effects, because the execute stage discards it on `out_skip`.

Top module: `cond_skip_unit`

## Requirements
- R1: After reset, and while reset is held, `out_valid`, `out_skip` and `out_adv` are 0 and no skip is pending. The first instruction after reset always executes.
- R2: Test code 0 passes when (b & a) != 0. Test code 1 passes when (b & a) == 0.
- R3: Test code 2 passes when b == a. Test code 3 passes when b != a.
- R4: Test code 4 passes when b > a and test code 5 passes when b < a, both unsigned.
- R5: Test code 6 passes when b > a and test code 7 passes when b < a, both as 16-bit two's-complement values. For example, code 7 with b = 0xFFFD and a = 0xFFFE passes.
- R6: A failing, unskipped test causes the next non-conditional instruction to be reported with `out_skip` = 1 and `out_adv` equal to that instruction's `in_len`. The instruction after it executes normally.
- R7: A conditional test that arrives while a skip is pending is skipped with `out_adv` = its own `in_len`, is not evaluated, and keeps the skip pending for the following instruction.
- R8: `out_valid` is `in_valid` delayed by one cycle. An instruction that executes reports `out_skip` = 0 and `out_adv` = 0, including a test that passes.
- R9: Cycles with `in_valid` = 0 leave a pending skip unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_is_cond | input | 1 | The presented instruction is a conditional test |
| in_cond_op | input | 3 | Test code 0..7 (see R2 to R5) |
| in_b | input | 16 | Operand b |
| in_a | input | 16 | Operand a |
| in_len | input | 2 | Encoded length of the presented instruction in words, 1..3 |
| out_valid | output | 1 | Result for the instruction presented one cycle earlier |
| out_skip | output | 1 | That instruction must be discarded |
| out_adv | output | 2 | Words to step over when skipped, else 0 |

## Verification
The hardest situation to reach from the ports is a chain of conditional tests inside a skip. A skipped test whose own operands would pass must still be passed over, with its own length, and must keep the skip alive. The stimulus builds this by first issuing a failing test. It then sends two conditional tests chosen to pass if they were evaluated, each with a different length, followed by a non-conditional instruction and a final instruction that must run. Idle gaps and a reset in the middle of a pending skip are placed in separate sequences, so that holding the pending state and clearing it are each seen on their own.

// File: rtl/cskip_pkg.sv
package cskip_pkg;

    // Condition test codes; the numeric values are decoded from in_cond_op.
    typedef enum logic [2:0] {
        TST_ANY_SET = 3'd0,
        TST_NONE_SET = 3'd1,
        TST_EQUAL = 3'd2,
        TST_DIFFER = 3'd3,
        TST_UGREATER = 3'd4,
        TST_ULESS = 3'd5,
        TST_SGREATER = 3'd6,
        TST_SLESS = 3'd7
    } test_code_e;

endpackage

// File: rtl/cskip_compare.sv
module cskip_compare
    import cskip_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [2:0]        code_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [WORD_W-1:0] a_i,
    output logic              pass_o
);

    logic              any_common;
    logic              eq;
    logic              u_gt;
    logic              u_lt;
    logic              s_gt;
    logic              s_lt;
    test_code_e        code;

    assign code       = test_code_e'(code_i);
    assign any_common = |(b_i & a_i);
    assign eq         = (b_i == a_i);
    assign u_gt       = (b_i > a_i);
    assign u_lt       = (b_i < a_i);
    assign s_gt       = ($signed(b_i) > $signed(a_i));
    assign s_lt       = ($signed(b_i) < $signed(a_i));

    always_comb begin
        unique case (code)
            TST_ANY_SET:  pass_o = any_common;
            TST_NONE_SET: pass_o = !any_common;
            TST_EQUAL:    pass_o = eq;
            TST_DIFFER:   pass_o = !eq;
            TST_UGREATER: pass_o = u_gt;
            TST_ULESS:    pass_o = u_lt;
            TST_SGREATER: pass_o = s_gt;
            TST_SLESS:    pass_o = s_lt;
            default:      pass_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/cskip_seq.sv
module cskip_seq #(
    parameter int LEN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             is_cond_i,
    input  logic             pass_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             pend_o,
    output logic             valid_o,
    output logic             skip_o,
    output logic [LEN_W-1:0] adv_o
);

    typedef struct packed {
        logic             pend;
        logic             vld;
        logic             skip;
        logic [LEN_W-1:0] adv;
    } seq_state_t;

    localparam seq_state_t RESET_STATE = '{pend: 1'b0, vld: 1'b0, skip: 1'b0, adv: '0};

    seq_state_t st_d;
    seq_state_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = valid_i;
        st_d.skip = 1'b0;
        st_d.adv  = '0;
        if (valid_i) begin
            if (st_q.pend) begin
                // Instruction is discarded; a skipped test extends the skip.
                st_d.skip = 1'b1;
                st_d.adv  = len_i;
                st_d.pend = is_cond_i;
            end else begin
                st_d.pend = is_cond_i && !pass_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o  = st_q.pend;
    assign valid_o = st_q.vld;
    assign skip_o  = st_q.skip;
    assign adv_o   = st_q.adv;

endmodule

// File: rtl/cond_skip_unit.sv
module cond_skip_unit #(
    parameter int WORD_W = 16,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_is_cond,
    input  logic [2:0]        in_cond_op,
    input  logic [WORD_W-1:0] in_b,
    input  logic [WORD_W-1:0] in_a,
    input  logic [LEN_W-1:0]  in_len,
    output logic              out_valid,
    output logic              out_skip,
    output logic [LEN_W-1:0]  out_adv
);

    logic test_pass;
    logic skip_pend;

    cskip_compare #(.WORD_W(WORD_W)) u_cmp (
        .code_i (in_cond_op),
        .b_i    (in_b),
        .a_i    (in_a),
        .pass_o (test_pass)
    );

    cskip_seq #(.LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (in_valid),
        .is_cond_i (in_is_cond),
        .pass_i    (test_pass),
        .len_i     (in_len),
        .pend_o    (skip_pend),
        .valid_o   (out_valid),
        .skip_o    (out_skip),
        .adv_o     (out_adv)
    );

endmodule

// File: rtl/cond_skip_chk.sv
module cond_skip_chk #(
    parameter int WORD_W = 16,
    parameter int LEN_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_is_cond,
    input logic [2:0]        in_cond_op,
    input logic [WORD_W-1:0] in_b,
    input logic [WORD_W-1:0] in_a,
    input logic [LEN_W-1:0]  in_len,
    input logic              out_valid,
    input logic              out_skip,
    input logic [LEN_W-1:0]  out_adv,
    input logic              skip_pend
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!out_valid && !out_skip && out_adv == '0 && !skip_pend));

    // R2
    bit_fail_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !skip_pend && in_is_cond && in_cond_op == 3'd0 && (in_b & in_a) == '0) |=> skip_pend);

    // R3
    equal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !skip_pend && in_is_cond && in_cond_op == 3'd2 && in_b == in_a) |=> !skip_pend);

    // R5
    signed_less_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !skip_pend && in_is_cond && in_cond_op == 3'd7 && !($signed(in_b) < $signed(in_a))) |=> skip_pend);

    // R6
    skip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && skip_pend) |=> (out_skip && out_adv == $past(in_len)));

    // R6
    skip_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && skip_pend && !in_is_cond) |=> !skip_pend);

    // R7
    chain_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && skip_pend && in_is_cond) |=> skip_pend);

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid) || $past(!rst_n));

    // R8
    exec_no_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_skip) |-> (out_adv == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid) |=> $stable(skip_pend));

endmodule

bind cond_skip_unit cond_skip_chk #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/test_cond_skip_unit.sv
module test_cond_skip_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_is_cond = 1'b0;
    logic [2:0]  in_cond_op = 3'd0;
    logic [15:0] in_b = '0;
    logic [15:0] in_a = '0;
    logic [1:0]  in_len = 2'd1;
    logic        out_valid;
    logic        out_skip;
    logic [1:0]  out_adv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic       r_vld;
    logic       r_skip;
    logic [1:0] r_adv;

    always #5 clk = ~clk;

    cond_skip_unit i_cond_skip_unit (.*);

    // {code, b, a, expect_pass, follower_len}
    localparam int NV = 20;
    localparam logic [37:0] VEC [NV] = '{
        {3'd0, 16'h0003, 16'h0002, 1'b1, 2'd2},   // R2
        {3'd0, 16'h0003, 16'h0004, 1'b0, 2'd3},   // R2
        {3'd1, 16'h0003, 16'h0002, 1'b0, 2'd1},   // R2
        {3'd1, 16'h0003, 16'h0004, 1'b1, 2'd2},   // R2
        {3'd2, 16'h0003, 16'h0003, 1'b1, 2'd1},   // R3
        {3'd2, 16'h0003, 16'h0002, 1'b0, 2'd2},   // R3
        {3'd3, 16'h0003, 16'h0002, 1'b1, 2'd3},   // R3
        {3'd3, 16'h0003, 16'h0003, 1'b0, 2'd3},   // R3
        {3'd4, 16'h0003, 16'h0002, 1'b1, 2'd1},   // R4
        {3'd4, 16'h0003, 16'h0003, 1'b0, 2'd2},   // R4
        {3'd4, 16'hFFFD, 16'h0002, 1'b1, 2'd1},   // R4
        {3'd5, 16'h0002, 16'h0003, 1'b1, 2'd2},   // R4
        {3'd5, 16'h0003, 16'h0003, 1'b0, 2'd1},   // R4
        {3'd5, 16'h7FFF, 16'h8000, 1'b1, 2'd3},   // R4
        {3'd7, 16'hFFFD, 16'hFFFE, 1'b1, 2'd2},   // R5
        {3'd7, 16'hFFFE, 16'hFFFD, 1'b0, 2'd2},   // R5
        {3'd6, 16'hFFFE, 16'hFFFD, 1'b1, 2'd1},   // R5
        {3'd6, 16'hFFFD, 16'hFFFE, 1'b0, 2'd3},   // R5
        {3'd6, 16'h7FFF, 16'h8000, 1'b1, 2'd2},   // R5
        {3'd7, 16'h8000, 16'h0001, 1'b1, 2'd1}    // R5
    };

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Drive at a falling edge, capture the registered result at the next one.
    task automatic issue(input logic cnd, input logic [2:0] op, input logic [15:0] b,
                         input logic [15:0] a, input logic [1:0] len);
        in_valid   = 1'b1;
        in_is_cond = cnd;
        in_cond_op = op;
        in_b       = b;
        in_a       = a;
        in_len     = len;
        @(negedge clk);
        r_vld  = out_valid;
        r_skip = out_skip;
        r_adv  = out_adv;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check("R8 idle valid", {3'b0, out_valid}, 4'd0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 valid", {3'b0, out_valid}, 4'd0);
        check("R1 skip", {3'b0, out_skip}, 4'd0);
        check("R1 adv", {2'b0, out_adv}, 4'd0);
        rst_n = 1'b1;

        // R1: first instruction after reset executes
        issue(1'b0, 3'd0, 16'h0, 16'h0, 2'd3);
        check("R1 first exec", {2'b0, r_vld, r_skip}, 4'b0010);

        // Table walk: R2..R5 outcome seen as skip of follower (R6, R8)
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  op;
            logic [15:0] vb;
            logic [15:0] va;
            logic        ps;
            logic [1:0]  ln;
            {op, vb, va, ps, ln} = VEC[i];
            issue(1'b1, op, vb, va, 2'd1);
            check("R8 test itself runs", {2'b0, r_vld, r_skip}, 4'b0010);
            issue(1'b0, 3'd0, 16'h0, 16'h0, ln);
            check("R2-5 follower skip", {3'b0, r_skip}, {3'b0, !ps});
            check("R6 adv", {2'b0, r_adv}, ps ? 4'd0 : {2'b0, ln});
            issue(1'b0, 3'd0, 16'h0, 16'h0, 2'd2);
            check("R6 resume", {3'b0, r_skip}, 4'd0);
        end

        // R7: chained tests inside a skip; these would pass if evaluated
        issue(1'b1, 3'd2, 16'h1, 16'h2, 2'd1);
        issue(1'b1, 3'd2, 16'h5, 16'h5, 2'd2);
        check("R7 chained skip 1", {1'b0, r_skip, r_adv}, {1'b0, 1'b1, 2'd2});
        issue(1'b1, 3'd0, 16'hF, 16'hF, 2'd3);
        check("R7 chained skip 2", {1'b0, r_skip, r_adv}, {1'b0, 1'b1, 2'd3});
        issue(1'b0, 3'd0, 16'h0, 16'h0, 2'd1);
        check("R7 final skip", {1'b0, r_skip, r_adv}, {1'b0, 1'b1, 2'd1});
        issue(1'b0, 3'd0, 16'h0, 16'h0, 2'd1);
        check("R7 resume", {1'b0, r_skip, r_adv}, 4'd0);

        // R8: passing test chain while running evaluates each test
        issue(1'b1, 3'd3, 16'h1, 16'h2, 2'd2);
        issue(1'b1, 3'd3, 16'h4, 16'h4, 2'd2);
        check("R8 passed test followed by test runs", {1'b0, r_skip, r_adv}, 4'd0);
        issue(1'b0, 3'd0, 16'h0, 16'h0, 2'd3);
        check("R6 after evaluated fail", {1'b0, r_skip, r_adv}, {1'b0, 1'b1, 2'd3});

        // R9: idle gap keeps the pending skip
        issue(1'b1, 3'd4, 16'h1, 16'h9, 2'd1);
        idle(3);
        issue(1'b0, 3'd0, 16'h0, 16'h0, 2'd2);
        check("R9 skip after gap", {1'b0, r_skip, r_adv}, {1'b0, 1'b1, 2'd2});

        // R1: reset clears a pending skip
        issue(1'b1, 3'd2, 16'h1, 16'h2, 2'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-skip", {1'b0, out_valid, out_skip, 1'b0}, 4'd0);
        rst_n = 1'b1;
        issue(1'b0, 3'd0, 16'h0, 16'h0, 2'd2);
        check("R1 pending cleared", {1'b0, r_vld, r_skip, 1'b0}, 4'b0100);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule